// File: doc/BRIEF.md
# DMA channel interrupt status unit

This unit collects the interrupt causes of a single disk DMA channel and presents them to the host. Two sources are tracked: the interrupt line coming from the drive side, and a one-cycle error pulse raised when a memory bus transaction of the DMA engine fails. Each source owns one sticky status bit. The status bits, their enables and a 64-bit capture of the failing bus address are reached through a word-aligned register port.

Software arms the sources once by writing ones into the enable-set register. After that the host interrupt line rises whenever an armed status bit is pending. An interrupt is valid when either bit is set. The handler reads the status word. On a bus error it also reads the captured address, low word then high word. It then writes ones into the clear register to drop the bits it has served.

The status, enable-set and clear views sit at separate word offsets. Status changes only by events and by writes to the clear register. Enables change only by writes to the set register.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is held and right after it, the status word, the enable word, both error-address words and `irq_out` are all zero.
- R2: A rising edge of `drv_irq` sets status bit 0. A level that stays high after the bit has been cleared does not set it again.
- R3: A `bus_err` pulse sets status bit 1. If bit 1 was clear, `bus_err_addr` is captured: bits 31:0 read at byte offset 0x00 and bits 63:32 read at byte offset 0x04.
- R4: A `bus_err` pulse that arrives while status bit 1 is already set leaves both error-address words unchanged.
- R5: Writing to byte offset 0x1C clears every status bit whose data bit is 1 and leaves bits written as 0 unchanged. Data bit 0 serves the drive source and data bit 1 the bus-error source.
- R6: When an event for a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R7: Writing to byte offset 0x14 sets every enable bit whose data bit is 1. Zeros written there do not clear enables. A read of 0x14 returns the enable word in bits 1:0.
- R8: `irq_out` is a register. It goes high one clock after some status bit and its enable bit are both 1, and it drops one clock after no such pair remains.
- R9: Byte offset 0x0C reads the status word in bits 1:0, with all upper bits zero. Writes to 0x00, 0x04 and 0x0C are ignored. Reads of unmapped or misaligned offsets return zero, and writes to misaligned offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drv_irq | input | 1 | Interrupt level from the drive side |
| bus_err | input | 1 | One-cycle pulse: a DMA memory transaction failed |
| bus_err_addr | input | EADDR_W (64) | Address of the failing transaction, valid with `bus_err` |
| reg_addr | input | ADDR_W (12) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe for the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
Assertions check on every cycle the following properties. An event always leaves its status bit set. A clear without a competing event always empties the bit. A pending bit holds until it is cleared. Enable bits never fall. The captured address is stable while the error bit is set and equals the address that came with a captured error. `irq_out` equals the previous cycle's armed-pending value. The bench scenarios show the behaviour that can only be seen through the register port. This covers the read decode, ignored and misaligned accesses, and the partial clear masks. It also covers the fact that a held drive level does not re-trigger after a clear, and the ordering of an event against a clear issued in the same cycle.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
package dis_pkg;
   // word indices; byte offset is index * 4
   localparam int IDX_ELO  = 0;
   localparam int IDX_EHI  = 1;
   localparam int IDX_STAT = 3;
   localparam int IDX_SET  = 5;
   localparam int IDX_CLR  = 7;
   // status bit positions
   localparam int SRC_DRV  = 0;
   localparam int SRC_BERR = 1;
   localparam int NUM_SRC  = 2;
endpackage

// File: rtl/dis_status_bit.sv
`timescale 1ns/1ps
module dis_status_bit #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_in,
   input  logic clr,
   output logic stat
);
   logic ev;

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= ev_in;
         end
         assign ev = ev_in & ~prev_q;
      end else begin : g_pulse
         assign ev = ev_in;
      end
   endgenerate

   // event has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n)   stat <= 1'b0;
      else if (ev)  stat <= 1'b1;
      else if (clr) stat <= 1'b0;
   end

   p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n & ev) |-> stat);
   p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n & clr & ~ev) |-> !stat);
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n & stat & ~clr) |-> stat);
endmodule

// File: rtl/dis_err_capture.sv
`timescale 1ns/1ps
module dis_err_capture #(
   parameter int EADDR_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               err_ev,
   input  logic               err_flag,
   input  logic [EADDR_W-1:0] addr_in,
   output logic [EADDR_W-1:0] addr_q
);
   logic take;
   assign take = err_ev & ~err_flag;

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= addr_in;
   end

   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n & err_flag) |-> $stable(addr_q));
   p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n & err_ev & ~err_flag) |-> (addr_q == $past(addr_in)));
endmodule

// File: rtl/dis_regfile.sv
`timescale 1ns/1ps
module dis_regfile
   import dis_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int EADDR_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic [NUM_SRC-1:0] stat,
   input  logic [EADDR_W-1:0] err_addr,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_SRC-1:0] clr_mask,
   output logic [NUM_SRC-1:0] en
);
   localparam int WIDX_W = ADDR_W - 2;
   localparam int EXT_W  = 2 * DATA_W;

   logic [WIDX_W-1:0] widx;
   logic              aligned;
   logic [EXT_W-1:0]  ea_ext;
   logic              sel_elo, sel_ehi, sel_stat, sel_set, sel_clr;
   logic [NUM_SRC-1:0] set_mask;
   logic              unused_wdata;

   assign widx     = reg_addr[ADDR_W-1:2];
   assign aligned  = (reg_addr[1:0] == 2'b00);
   assign ea_ext   = EXT_W'(err_addr);
   assign sel_elo  = aligned && (widx == WIDX_W'(IDX_ELO));
   assign sel_ehi  = aligned && (widx == WIDX_W'(IDX_EHI));
   assign sel_stat = aligned && (widx == WIDX_W'(IDX_STAT));
   assign sel_set  = aligned && (widx == WIDX_W'(IDX_SET));
   assign sel_clr  = aligned && (widx == WIDX_W'(IDX_CLR));
   assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_SRC];

   assign set_mask = (reg_wr && sel_set) ? reg_wdata[NUM_SRC-1:0] : '0;
   assign clr_mask = (reg_wr && sel_clr) ? reg_wdata[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) en <= '0;
      else        en <= en | set_mask;
   end

   always_comb begin
      rdata = '0;
      if (sel_elo)       rdata = ea_ext[DATA_W-1:0];
      else if (sel_ehi)  rdata = ea_ext[EXT_W-1:DATA_W];
      else if (sel_stat) rdata = DATA_W'(stat);
      else if (sel_set)  rdata = DATA_W'(en);
   end

   p_enable_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((en & $past(en)) == $past(en)));
   p_clear_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |-> (clr_mask == '0));
endmodule

// File: rtl/dma_irq_status.sv
`timescale 1ns/1ps
module dma_irq_status
   import dis_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int EADDR_W = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               drv_irq,
   input  logic               bus_err,
   input  logic [EADDR_W-1:0] bus_err_addr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_out
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach byte offset 0x1C");
      end
      if (DATA_W < NUM_SRC) begin : g_bad_data
         $error("DATA_W narrower than the status word");
      end
      if (EADDR_W > 2 * DATA_W || EADDR_W < 1) begin : g_bad_eaddr
         $error("EADDR_W must fit in two data words");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_ev;
   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] clr_mask;
   logic [NUM_SRC-1:0] en_q;
   logic [EADDR_W-1:0] err_addr_q;
   logic               armed;

   assign src_ev[SRC_DRV]  = drv_irq;
   assign src_ev[SRC_BERR] = bus_err;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         dis_status_bit #(.EDGE_MODE(i == SRC_DRV)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_in (src_ev[i]),
            .clr   (clr_mask[i]),
            .stat  (stat_q[i])
         );
      end
   endgenerate

   dis_err_capture #(.EADDR_W(EADDR_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_ev   (bus_err),
      .err_flag (stat_q[SRC_BERR]),
      .addr_in  (bus_err_addr),
      .addr_q   (err_addr_q)
   );

   dis_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EADDR_W(EADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .stat      (stat_q),
      .err_addr  (err_addr_q),
      .rdata     (reg_rdata),
      .clr_mask  (clr_mask),
      .en        (en_q)
   );

   assign armed = |(stat_q & en_q);

   generate
      if (OUT_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= armed;
         end
         assign irq_out = irq_q;

         p_irq_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (irq_out == $past(armed)));
      end else begin : g_irq_comb
         assign irq_out = armed;
      end
   endgenerate

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (stat_q == '0 && en_q == '0));
endmodule

// File: tb/dma_irq_status_tb_top.sv
`timescale 1ns/1ps
module dma_irq_status_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        drv_irq = 1'b0;
   logic        bus_err = 1'b0;
   logic [63:0] bus_err_addr = '0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   localparam logic [11:0] A_ELO = 12'h000, A_EHI = 12'h004, A_STAT = 12'h00C,
                           A_SET = 12'h014, A_CLR = 12'h01C;

   always #2.5 clk = ~clk;

   dma_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .bus_err(bus_err),
      .bus_err_addr(bus_err_addr), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic err_pulse(input logic [63:0] a);
      @(negedge clk);
      bus_err = 1'b1; bus_err_addr = a;
      @(negedge clk);
      bus_err = 1'b0; bus_err_addr = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R1 irq during reset", irq_out, 0);
      rst_n = 1'b1;
      rd(A_STAT, v); chk("R1 status", v, 0);
      rd(A_SET, v);  chk("R1 enable", v, 0);
      rd(A_ELO, v);  chk("R1 err low", v, 0);
      rd(A_EHI, v);  chk("R1 err high", v, 0);
      chk("R1 irq after reset", irq_out, 0);
   endtask

   task automatic t_drive_edge();
      logic [31:0] v;
      @(negedge clk); drv_irq = 1'b1;
      rd(A_STAT, v); chk("R2 edge sets bit0", v, 1);
      repeat (2) @(negedge clk);
      chk("R8 no irq when disabled", irq_out, 0);
      wr(A_CLR, 32'h1);
      rd(A_STAT, v); chk("R5 clear bit0", v, 0);
      repeat (3) @(negedge clk);
      rd(A_STAT, v); chk("R2 held level no retrigger", v, 0);
      drv_irq = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr(A_SET, 32'h3);
      rd(A_SET, v); chk("R7 enable set", v, 3);
      wr(A_SET, 32'h0);
      rd(A_SET, v); chk("R7 zeros keep enables", v, 3);
   endtask

   task automatic t_irq_out();
      @(negedge clk); drv_irq = 1'b1;
      @(negedge clk);
      chk("R8 irq one cycle late", irq_out, 0);
      @(negedge clk);
      chk("R8 irq high", irq_out, 1);
      @(negedge clk);
      reg_addr = A_CLR; reg_wdata = 32'h1; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      chk("R8 irq still high after clear edge", irq_out, 1);
      @(negedge clk);
      chk("R8 irq dropped", irq_out, 0);
      drv_irq = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_bus_err();
      logic [31:0] v;
      err_pulse(64'h1234_5678_9ABC_DEF0);
      rd(A_STAT, v); chk("R3 bit1 set", v, 2);
      chk("R8 irq on bus error", irq_out, 1);
      rd(A_ELO, v);  chk("R3 addr low", v, 32'h9ABC_DEF0);
      rd(A_EHI, v);  chk("R3 addr high", v, 32'h1234_5678);
      err_pulse(64'hAAAA_BBBB_CCCC_DDDD);
      rd(A_ELO, v);  chk("R4 low kept", v, 32'h9ABC_DEF0);
      rd(A_EHI, v);  chk("R4 high kept", v, 32'h1234_5678);
      wr(A_CLR, 32'h2);
      rd(A_STAT, v); chk("R5 clear bit1", v, 0);
      err_pulse(64'h0F0F_0000_0000_7777);
      rd(A_ELO, v);  chk("R3 recapture low", v, 32'h0000_7777);
      rd(A_EHI, v);  chk("R3 recapture high", v, 32'h0F0F_0000);
      wr(A_CLR, 32'h2);
   endtask

   task automatic t_partial_clear();
      logic [31:0] v;
      @(negedge clk);
      drv_irq = 1'b1; bus_err = 1'b1; bus_err_addr = 64'h55;
      @(negedge clk);
      bus_err = 1'b0;
      rd(A_STAT, v); chk("R2 R3 both set", v, 3);
      wr(A_CLR, 32'h1);
      rd(A_STAT, v); chk("R5 partial clear keeps bit1", v, 2);
      wr(A_CLR, 32'h2);
      rd(A_STAT, v); chk("R5 second clear", v, 0);
      drv_irq = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      err_pulse(64'h1);
      @(negedge clk);
      bus_err = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h2; reg_wr = 1'b1;
      @(negedge clk);
      bus_err = 1'b0; reg_wr = 1'b0;
      rd(A_STAT, v); chk("R6 bus error beats clear", v, 2);
      @(negedge clk);
      drv_irq = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h3; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_STAT, v); chk("R6 drive edge beats clear", v, 1);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      logic [31:0] lo;
      rd(A_ELO, lo);
      wr(A_ELO, 32'hFFFF_FFFF);
      rd(A_ELO, v);  chk("R9 err low not writable", v, lo);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R9 status not writable", v, 1);
      wr(12'h01D, 32'h3);
      rd(A_STAT, v); chk("R9 misaligned write ignored", v, 1);
      rd(12'h00D, v); chk("R9 misaligned read zero", v, 0);
      rd(12'h008, v); chk("R9 unmapped 0x08 zero", v, 0);
      rd(A_CLR, v);  chk("R9 clear reads zero", v, 0);
      wr(A_CLR, 32'h3);
      drv_irq = 1'b0;
      rd(A_STAT, v); chk("R5 final clear", v, 0);
   endtask

   initial begin
      t_reset();
      t_drive_edge();
      t_enable();
      t_irq_out();
      t_bus_err();
      t_partial_clear();
      t_same_cycle();
      t_ignored();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule